// File: doc/BRIEF.md
# Firmware Service Register Block

This block is a small slave on a simple word-wide register bus. It gives boot firmware a handful of system services. A write to the halt register stops the system and carries an exit code out. Two read-only registers report which processor is asking and how many processors exist. A paired port/level write drives one level-sensitive interrupt line per processor. A one-character console receive buffer and a console transmit register, each with its own status byte, complete the set.

Only the low five address bits are decoded, so the eight registers appear again every 32 bytes. Each register sits on a word boundary, and its byte is carried on byte lane 0 (bits 7:0). The one exception is the interrupt register, which also uses lane 1 (bits 15:8) for the drive level. Read data is registered and presented zero-extended to 32 bits. Characters arriving from outside on a valid/data pair are held until firmware reads them.

Top module: `fwglue_regs`

## Requirements
- R1: Only address bits 4:0 are decoded. An access at offset X+32 behaves like one at offset X.
- R2: After reset the following values hold. rd_data, irq_lines, halt_pulse, exit_code, tx_strobe and tx_byte are all zero. Transmit status (offset 28) reads 1. Receive status (offset 20) and receive data (offset 16) read 0.
- R3: A read strobe loads rd_data at the next clock edge. Bits 31:8 are zero. Write-only offsets (0, 8) and unmapped offsets read as zero. rd_data holds its value between reads.
- R4: A lane-0 write to offset 0 gives a one-cycle halt_pulse after the clock edge. It also latches bits 7:0 of the write data on exit_code.
- R5: A read of offset 4 returns the requester ID presented with the strobe. A read of offset 12 returns the NCPU parameter (default 4).
- R6: A write to offset 8 with byte enables 0 and 1 both set selects the line given by data bits 7:0. That line is set to 1 if bits 15:8 are nonzero and to 0 if they are zero.
- R7: A write to offset 8 with byte enable 0 set and byte enable 1 clear drives the selected line to 0.
- R8: An interrupt write whose port number is NCPU or above changes no line.
- R9: When receive status is zero, rx_valid captures rx_char into the receive buffer and sets status to 1. While status is nonzero, arriving characters are dropped.
- R10: A read of offset 16 returns the buffered character and clears both the receive buffer and the receive status.
- R11: A write to offset 24 pulses tx_strobe for one cycle with tx_byte equal to data bits 7:0. The byte stays readable at offset 24, and transmit status becomes 1.
- R12: Writes to offsets 16, 20 and 28 store data bits 7:0 directly as receive buffer, receive status and transmit status.
- R13: A write with byte enable 0 clear changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Byte address; bits 4:0 decoded |
| bus_be | input | 4 | Byte enables, lane 0 = bits 7:0 |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| req_id | input | ID_W | ID of the processor making the access |
| rx_valid | input | 1 | Incoming console character valid |
| rx_char | input | 8 | Incoming console character |
| rd_data | output | 32 | Registered read data |
| halt_pulse | output | 1 | One-cycle halt request |
| exit_code | output | 8 | Last exit code written |
| irq_lines | output | NCPU | Level interrupt line per processor |
| tx_strobe | output | 1 | One-cycle transmit byte strobe |
| tx_byte | output | 8 | Last transmitted byte |

## Verification
The interrupt register is tried with four kinds of write. A two-byte write with a nonzero level, a two-byte write with level zero and a single-byte write tell apart the role of byte lane 1 and the level value. A write with an out-of-range port number shows that the port is range-checked rather than truncated. The receive path is driven both with the buffer empty and with it full, which separates capture from dropping. A second read of the receive data shows that the read consumes the character. Reads at aliased addresses, with different requester IDs, and writes with lane 0 disabled tell apart full-address decode from five-bit decode and a masked write from an unmasked one.

// File: rtl/fwglue_pkg.sv
package fwglue_pkg;
  localparam int BUS_W  = 32;
  localparam int BYTE_W = 8;
  localparam int LANES  = BUS_W / BYTE_W;
  localparam int OFS_W  = 5;

  localparam logic [OFS_W-1:0] OFS_HALT  = 5'd0;
  localparam logic [OFS_W-1:0] OFS_CPUID = 5'd4;
  localparam logic [OFS_W-1:0] OFS_IRQ   = 5'd8;
  localparam logic [OFS_W-1:0] OFS_NCPU  = 5'd12;
  localparam logic [OFS_W-1:0] OFS_RXD   = 5'd16;
  localparam logic [OFS_W-1:0] OFS_RXS   = 5'd20;
  localparam logic [OFS_W-1:0] OFS_TXD   = 5'd24;
  localparam logic [OFS_W-1:0] OFS_TXS   = 5'd28;

  typedef struct packed {
    logic halt;
    logic cpuid;
    logic irq;
    logic ncpu;
    logic rxd;
    logic rxs;
    logic txd;
    logic txs;
  } regsel_t;
endpackage

// File: rtl/fwglue_decode.sv
module fwglue_decode
  import fwglue_pkg::*;
(
  input  logic [OFS_W-1:0] ofs,
  output regsel_t          sel
);
  always_comb begin
    sel = '0;
    case (ofs)
      OFS_HALT:  sel.halt  = 1'b1;
      OFS_CPUID: sel.cpuid = 1'b1;
      OFS_IRQ:   sel.irq   = 1'b1;
      OFS_NCPU:  sel.ncpu  = 1'b1;
      OFS_RXD:   sel.rxd   = 1'b1;
      OFS_RXS:   sel.rxs   = 1'b1;
      OFS_TXD:   sel.txd   = 1'b1;
      OFS_TXS:   sel.txs   = 1'b1;
      default:   sel       = '0;
    endcase
  end
endmodule

// File: rtl/fwglue_irq.sv
module fwglue_irq #(
  parameter int NCPU = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_irq,
  input  logic [7:0]      port,
  input  logic            lvl_en,
  input  logic [7:0]      lvl,
  output logic [NCPU-1:0] irq_lines
);
  logic            drive_lvl;
  logic [NCPU-1:0] line_q;
  logic [NCPU-1:0] line_d;

  // level is taken from lane 1 only when that lane is enabled
  assign drive_lvl = lvl_en & (|lvl);

  for (genvar g = 0; g < NCPU; g++) begin : g_line
    logic hit;
    assign hit = wr_irq && (port == 8'(g));

    always_comb begin
      line_d[g] = line_q[g];
      if (hit) line_d[g] = drive_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   line_q[g] <= 1'b0;
      else if (hit) line_q[g] <= line_d[g];
    end
  end

  assign irq_lines = line_q;
endmodule

// File: rtl/fwglue_console.sv
module fwglue_console
  import fwglue_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  regsel_t           sel,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_char,
  output logic [BYTE_W-1:0] rx_buf,
  output logic [BYTE_W-1:0] rx_stat,
  output logic [BYTE_W-1:0] tx_buf,
  output logic [BYTE_W-1:0] tx_stat,
  output logic              tx_strobe
);
  logic [BYTE_W-1:0] rxb_q, rxb_d, rxs_q, rxs_d;
  logic [BYTE_W-1:0] txb_q, txb_d, txs_q, txs_d;
  logic              txp_q, txp_d;
  logic              capture, consume;

  assign capture = rx_valid && (rxs_q == '0);
  assign consume = rd_en && sel.rxd;

  // priority: direct bus write, then capture of a new character, then consume
  always_comb begin
    rxb_d = rxb_q;
    rxs_d = rxs_q;
    if (wr_en && sel.rxd) rxb_d = wbyte;
    else if (capture)     rxb_d = rx_char;
    else if (consume)     rxb_d = '0;
    if (wr_en && sel.rxs) rxs_d = wbyte;
    else if (capture)     rxs_d = 8'd1;
    else if (consume)     rxs_d = '0;
  end

  always_comb begin
    txb_d = txb_q;
    txs_d = txs_q;
    txp_d = 1'b0;
    if (wr_en && sel.txd) begin
      txb_d = wbyte;
      txs_d = 8'd1;
      txp_d = 1'b1;
    end else if (wr_en && sel.txs) begin
      txs_d = wbyte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxb_q <= '0;
      rxs_q <= '0;
      txb_q <= '0;
      txs_q <= 8'd1;
      txp_q <= 1'b0;
    end else begin
      rxb_q <= rxb_d;
      rxs_q <= rxs_d;
      txb_q <= txb_d;
      txs_q <= txs_d;
      txp_q <= txp_d;
    end
  end

  assign rx_buf    = rxb_q;
  assign rx_stat   = rxs_q;
  assign tx_buf    = txb_q;
  assign tx_stat   = txs_q;
  assign tx_strobe = txp_q;
endmodule

// File: rtl/fwglue_regs.sv
module fwglue_regs
  import fwglue_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int AW   = 8,
  localparam int ID_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic [LANES-1:0]  bus_be,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic [ID_W-1:0]   req_id,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_char,
  output logic [BUS_W-1:0]  rd_data,
  output logic              halt_pulse,
  output logic [BYTE_W-1:0] exit_code,
  output logic [NCPU-1:0]   irq_lines,
  output logic              tx_strobe,
  output logic [BYTE_W-1:0] tx_byte
);
  regsel_t           sel;
  logic              wr_en;
  logic [BYTE_W-1:0] wbyte;
  logic [BYTE_W-1:0] rx_buf, rx_stat, tx_buf, tx_stat;
  logic [BYTE_W-1:0] rd_byte;
  logic [BUS_W-1:0]  rd_q, rd_d;
  logic              halt_q, halt_d;
  logic [BYTE_W-1:0] exit_q, exit_d;
  logic              unused_bits;

  assign unused_bits = ^{bus_addr[AW-1:OFS_W], bus_be[LANES-1:2], bus_wdata[BUS_W-1:2*BYTE_W]};

  assign wr_en = bus_wr && bus_be[0];
  assign wbyte = bus_wdata[BYTE_W-1:0];

  fwglue_decode u_decode (
    .ofs (bus_addr[OFS_W-1:0]),
    .sel (sel)
  );

  fwglue_irq #(.NCPU(NCPU)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_irq    (wr_en && sel.irq),
    .port      (wbyte),
    .lvl_en    (bus_be[1]),
    .lvl       (bus_wdata[2*BYTE_W-1:BYTE_W]),
    .irq_lines (irq_lines)
  );

  fwglue_console u_console (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (bus_rd),
    .sel       (sel),
    .wbyte     (wbyte),
    .rx_valid  (rx_valid),
    .rx_char   (rx_char),
    .rx_buf    (rx_buf),
    .rx_stat   (rx_stat),
    .tx_buf    (tx_buf),
    .tx_stat   (tx_stat),
    .tx_strobe (tx_strobe)
  );

  // read byte select; write-only and unmapped offsets give zero
  always_comb begin
    rd_byte = '0;
    unique case (1'b1)
      sel.cpuid: rd_byte = BYTE_W'(req_id);
      sel.ncpu:  rd_byte = BYTE_W'(NCPU);
      sel.rxd:   rd_byte = rx_buf;
      sel.rxs:   rd_byte = rx_stat;
      sel.txd:   rd_byte = tx_buf;
      sel.txs:   rd_byte = tx_stat;
      default:   rd_byte = '0;
    endcase
    rd_d = {{(BUS_W-BYTE_W){1'b0}}, rd_byte};
  end

  always_comb begin
    halt_d = wr_en && sel.halt;
    exit_d = halt_d ? wbyte : exit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= '0;
    else if (bus_rd) rd_q <= rd_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
      exit_q <= '0;
    end else begin
      halt_q <= halt_d;
      exit_q <= exit_d;
    end
  end

  assign rd_data    = rd_q;
  assign halt_pulse = halt_q;
  assign exit_code  = exit_q;
  assign tx_byte    = tx_buf;
endmodule

// File: rtl/fwglue_chk.sv
module fwglue_chk #(
  parameter int NCPU = 4,
  parameter int AW   = 8,
  parameter int ID_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   bus_addr,
  input logic [3:0]      bus_be,
  input logic            bus_rd,
  input logic            bus_wr,
  input logic [31:0]     bus_wdata,
  input logic [ID_W-1:0] req_id,
  input logic [31:0]     rd_data,
  input logic            halt_pulse,
  input logic [7:0]      exit_code,
  input logic [NCPU-1:0] irq_lines,
  input logic            tx_strobe,
  input logic [7:0]      tx_byte
);
  p_halt_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_be[0] && bus_addr[4:0] == 5'd0) |=> (halt_pulse && exit_code == $past(bus_wdata[7:0])));

  p_halt_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    halt_pulse |-> $past(bus_wr && bus_be[0] && bus_addr[4:0] == 5'd0));

  p_tx_emit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_be[0] && bus_addr[4:0] == 5'd24) |=> (tx_strobe && tx_byte == $past(bus_wdata[7:0])));

  p_rd_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31:8] == 24'd0);

  p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(rd_data));

  p_cpuid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[4:0] == 5'd4) |=> rd_data[7:0] == 8'($past(req_id)));

  p_irq_one_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_lines ^ $past(irq_lines)) <= 1);

  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_be[0] && bus_addr[4:0] == 5'd8) |=> $stable(irq_lines));
endmodule

bind fwglue_regs fwglue_chk #(.NCPU(NCPU), .AW(AW), .ID_W(ID_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_be     (bus_be),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .bus_wdata  (bus_wdata),
  .req_id     (req_id),
  .rd_data    (rd_data),
  .halt_pulse (halt_pulse),
  .exit_code  (exit_code),
  .irq_lines  (irq_lines),
  .tx_strobe  (tx_strobe),
  .tx_byte    (tx_byte)
);

// File: tb/fwglue_regs_tb.sv
module fwglue_regs_tb;
  localparam int NCPU = 4;
  localparam int AW   = 8;
  localparam int ID_W = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [3:0]      bus_be = '0;
  logic            bus_rd = 1'b0;
  logic            bus_wr = 1'b0;
  logic [31:0]     bus_wdata = '0;
  logic [ID_W-1:0] req_id = '0;
  logic            rx_valid = 1'b0;
  logic [7:0]      rx_char = '0;
  logic [31:0]     rd_data;
  logic            halt_pulse;
  logic [7:0]      exit_code;
  logic [NCPU-1:0] irq_lines;
  logic            tx_strobe;
  logic [7:0]      tx_byte;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #2.5 clk = ~clk;

  fwglue_regs #(.NCPU(NCPU), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .req_id(req_id),
    .rx_valid(rx_valid), .rx_char(rx_char), .rd_data(rd_data),
    .halt_pulse(halt_pulse), .exit_code(exit_code), .irq_lines(irq_lines),
    .tx_strobe(tx_strobe), .tx_byte(tx_byte)
  );

  typedef struct packed {
    logic        rd;
    logic [7:0]  addr;
    logic [3:0]  be;
    logic [31:0] data;   // write data, or expected read data
    logic [1:0]  id;
    logic [3:0]  req;    // requirement number for messages
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 8'h1C, 4'hF, 32'h1,    2'd0, 4'd2},  // R2 tx status 1
    '{1'b1, 8'h14, 4'hF, 32'h0,    2'd0, 4'd2},  // R2 rx status 0
    '{1'b1, 8'h10, 4'hF, 32'h0,    2'd0, 4'd2},  // R2 rx buffer 0
    '{1'b1, 8'h0C, 4'hF, 32'h4,    2'd0, 4'd5},  // R5 count
    '{1'b1, 8'h04, 4'hF, 32'h3,    2'd3, 4'd5},  // R5 id 3
    '{1'b1, 8'h24, 4'hF, 32'h1,    2'd1, 4'd1},  // R1 alias of id reg
    '{1'b0, 8'h10, 4'h1, 32'h41,   2'd0, 4'd12}, // R12 force rx buffer
    '{1'b1, 8'h10, 4'hF, 32'h41,   2'd0, 4'd12},
    '{1'b1, 8'h10, 4'hF, 32'h0,    2'd0, 4'd10}, // R10 consumed
    '{1'b0, 8'h14, 4'hF, 32'h5,    2'd0, 4'd12}, // R12 force rx status
    '{1'b1, 8'h14, 4'hF, 32'h5,    2'd0, 4'd12},
    '{1'b0, 8'h14, 4'hF, 32'h0,    2'd0, 4'd12},
    '{1'b0, 8'h1C, 4'hF, 32'h0,    2'd0, 4'd12}, // R12 force tx status
    '{1'b1, 8'h1C, 4'hF, 32'h0,    2'd0, 4'd12},
    '{1'b0, 8'h1C, 4'hF, 32'h1,    2'd0, 4'd12},
    '{1'b1, 8'h02, 4'hF, 32'h0,    2'd0, 4'd3},  // R3 unmapped
    '{1'b1, 8'h00, 4'hF, 32'h0,    2'd0, 4'd3},  // R3 write-only
    '{1'b0, 8'h10, 4'h2, 32'h7700, 2'd0, 4'd13}, // R13 lane 0 off
    '{1'b1, 8'h10, 4'hF, 32'h0,    2'd0, 4'd13},
    '{1'b0, 8'h1C, 4'hE, 32'h0,    2'd0, 4'd13},
    '{1'b1, 8'h1C, 4'hF, 32'h1,    2'd0, 4'd13}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // one-cycle access; returns at the negedge after the capturing edge
  task automatic bus_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [1:0] id, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; req_id = id; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = rd_data;
  endtask

  task automatic rx_push(input logic [7:0] c);
    @(negedge clk);
    rx_valid = 1'b1; rx_char = c;
    @(negedge clk);
    rx_valid = 1'b0; rx_char = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state at the ports
    check("R2 rd_data", rd_data, 32'h0);
    check("R2 irq", 32'(irq_lines), 32'h0);
    check("R2 halt", {31'd0, halt_pulse}, 32'h0);
    check("R2 exit", 32'(exit_code), 32'h0);
    check("R2 tx", {23'd0, tx_strobe, tx_byte}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].rd) begin
        bus_read(TBL[i].addr, TBL[i].id, r);
        check($sformatf("R%0d vec %0d", TBL[i].req, i), r, TBL[i].data);
      end else begin
        bus_write(TBL[i].addr, TBL[i].be, TBL[i].data);
      end
    end

    // R3 data held between reads
    @(negedge clk);
    check("R3 hold", rd_data, 32'h1);

    // R9 capture when empty, drop when full; R10 consume
    rx_push(8'h5A);
    bus_read(8'h14, 2'd0, r); check("R9 status", r, 32'h1);
    rx_push(8'h33);
    bus_read(8'h10, 2'd0, r); check("R9 drop / R10 data", r, 32'h5A);
    bus_read(8'h14, 2'd0, r); check("R10 status clear", r, 32'h0);

    // R11 transmit
    bus_write(8'h1C, 4'h1, 32'h0);
    bus_write(8'h18, 4'h1, 32'h6B);
    check("R11 strobe", {31'd0, tx_strobe}, 32'h1);
    check("R11 byte", 32'(tx_byte), 32'h6B);
    @(negedge clk);
    check("R11 strobe width", {31'd0, tx_strobe}, 32'h0);
    bus_read(8'h18, 2'd0, r); check("R11 readback", r, 32'h6B);
    bus_read(8'h1C, 2'd0, r); check("R11 status", r, 32'h1);

    // R4 halt
    bus_write(8'h00, 4'h1, 32'h2C);
    check("R4 pulse", {31'd0, halt_pulse}, 32'h1);
    check("R4 code", 32'(exit_code), 32'h2C);
    @(negedge clk);
    check("R4 pulse width", {31'd0, halt_pulse}, 32'h0);

    // R6 R7 R8 interrupts
    bus_write(8'h08, 4'h3, 32'h0102);
    check("R6 port2 on", 32'(irq_lines), 32'h4);
    bus_write(8'h08, 4'h3, 32'h0100);
    check("R6 port0 on", 32'(irq_lines), 32'h5);
    bus_write(8'h08, 4'h3, 32'h0000);
    check("R6 level zero", 32'(irq_lines), 32'h4);
    bus_write(8'h08, 4'h1, 32'hFF02);
    check("R7 single byte", 32'(irq_lines), 32'h0);
    bus_write(8'h08, 4'h3, 32'h0107);
    check("R8 out of range", 32'(irq_lines), 32'h0);
    bus_write(8'h08, 4'h3, 32'h0104);
    check("R8 port NCPU", 32'(irq_lines), 32'h0);
    bus_write(8'h28, 4'h3, 32'h0103);
    check("R1 alias irq", 32'(irq_lines), 32'h8);
    bus_write(8'h08, 4'h2, 32'h0100);
    check("R13 irq lane0 off", 32'(irq_lines), 32'h8);

    // R2 reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R2 irq after reset", 32'(irq_lines), 32'h0);
    check("R2 exit after reset", 32'(exit_code), 32'h0);
    rst_n = 1'b1;
    bus_read(8'h1C, 2'd0, r); check("R2 tx status after reset", r, 32'h1);
    bus_read(8'h18, 2'd0, r); check("R2 tx buffer after reset", r, 32'h0);

    done = 1'b1;
    summary();
  end
endmodule